// File: doc/BRIEF.md
# Configuration Load Sequencer

This block is a hardware master that walks a programmable-logic fabric through a full configuration load, with no software involved. After a start pulse it checks the five-bit mode-select strap and derives from it the clock-to-data ratio and the data-bus width. It then drives the fabric's reset request and follows the reported fabric mode from reset through configuration. During configuration it forwards every image word from a valid/ready stream to a data write port. It closes the load by sending a fixed burst of configuration clocks and waiting for user mode.

Every wait in the sequence is bounded by a timer made of a cycle divider, which produces a tick, and a tick limit. When a wait runs past the limit, the run ends with a timeout result. Each run ends with a one-cycle done strobe and a held result code.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, ctl_en_o=0, ctl_nce_o=1, ctl_ncfg_pull_o=0, ctl_stream_en_o=0, img_ready_o=0, result_o=0 (none), and every strobe output is low.
- R2: The mode-select value is rejected when msel_i[4]=1 or msel_i[1:0]=2'b11. A start with a rejected value gives result_o=2 (fail) with a done_o pulse, and leaves every control output unchanged.
- R3: When a run starts, ctl_wide_o takes msel_i[3]. ctl_ratio_o takes msel_i[1:0], incremented by one when msel_i[3]=1 and msel_i[1:0] is nonzero.
- R4: A start with an accepted value drives ctl_nce_o=0, ctl_en_o=1 and ctl_ncfg_pull_o=1, then waits for fab_mode_i=1 (reset phase).
- R5: Once the fabric reports reset phase, ctl_ncfg_pull_o returns to 0 and the block waits for fab_mode_i=2 (config phase).
- R6: Entry to config phase gives exactly one nst_clr_o pulse and sets ctl_stream_en_o=1. img_ready_o is high only while the image is being streamed.
- R7: Each accepted image word appears on wr_data_o with wr_valid_o one cycle later, in arrival order. The word marked with img_last_i ends the stream.
- R8: After the last word the block waits until conf_done_i or nstatus_i is 1. It then clears ctl_stream_en_o and pulses dclk_clr_o.
- R9: One cycle later it pulses dclk_req_o while dclk_cnt_o equals DCLK_PULSES (4). It then waits for dclk_done_i and pulses dclk_clr_o again: two clears and one request per run.
- R10: The block then waits for fab_mode_i=4 (user mode), drives ctl_en_o=0, and ends with result_o=1 (pass) and a done_o pulse.
- R11: A wait that is not met within TICK_LIMIT ticks of TICK_DIV cycles ends the run with result_o=3 (timeout). With TICK_DIV=4 and TICK_LIMIT=6, a stalled reset-phase wait reports done_o 26 cycles after the cycle that presented start_i.
- R12: start_i is ignored while a run is in progress, and at most one of nst_clr_o, dclk_clr_o, dclk_req_o and done_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a load when idle |
| msel_i | input | 5 | Mode-select strap value |
| fab_mode_i | input | 3 | Fabric mode status (0 off, 1 reset, 2 config, 3 init, 4 user, 5 undefined) |
| conf_done_i | input | 1 | Configuration-done monitor bit |
| nstatus_i | input | 1 | Status monitor bit |
| dclk_done_i | input | 1 | Configuration clock burst finished |
| img_valid_i | input | 1 | Image word valid |
| img_data_i | input | DATA_W | Image word |
| img_last_i | input | 1 | Marks the final image word |
| img_ready_o | output | 1 | Image word accepted this cycle when valid |
| ctl_en_o | output | 1 | Manager owns the configuration inputs |
| ctl_nce_o | output | 1 | Chip-enable, active low |
| ctl_ncfg_pull_o | output | 1 | Holds the fabric in reset |
| ctl_stream_en_o | output | 1 | Configuration data path enabled |
| ctl_ratio_o | output | 2 | Clock-to-data ratio code |
| ctl_wide_o | output | 1 | Wide configuration bus |
| dclk_cnt_o | output | DCLK_CNT_W | Configuration clocks requested |
| dclk_req_o | output | 1 | Strobe: start the clock burst |
| dclk_clr_o | output | 1 | Strobe: clear the burst-done flag |
| nst_clr_o | output | 1 | Strobe: clear the status interrupt |
| wr_valid_o | output | 1 | Data write strobe |
| wr_data_o | output | DATA_W | Data write word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Strobe: run finished |
| result_o | output | 2 | 0 none, 1 pass, 2 fail, 3 timeout |

## Verification
A wrong sequencer state shows up at the ports within a cycle or two of the fabric's reply. A control bit goes out with the wrong level, a strobe is missing or doubled, or the stand-in fabric never advances, so the run ends with a timeout code instead of a pass. A fault in the timer moves the done strobe away from its exact expected cycle in the stalled-reset run. A fault in the strap decode shows as a wrong ratio or width code, which is read on every run. A fault in the word path shows as the first written word that differs from the word that was sent.

// File: rtl/cfg_load_pkg.sv
// Shared types for the configuration load sequencer.
// Assumes: fabric mode codes are fixed by the fabric's status encoding.
package cfg_load_pkg;

    typedef enum logic [2:0] {
        FAB_OFF    = 3'd0,
        FAB_RESET  = 3'd1,
        FAB_CONFIG = 3'd2,
        FAB_INIT   = 3'd3,
        FAB_USER   = 3'd4,
        FAB_UNDEF  = 3'd5
    } fab_mode_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_PASS    = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } run_result_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT_RST,
        SQ_WAIT_CFG,
        SQ_STREAM,
        SQ_WAIT_CONF,
        SQ_DCLK_GO,
        SQ_WAIT_DCLK,
        SQ_WAIT_USER
    } seq_state_e;

    typedef struct packed {
        logic       bad;
        logic       wide;
        logic [1:0] ratio;
    } msel_cfg_t;

endpackage

// File: rtl/cfg_msel_decode.sv
// Strap decoder: turns the mode-select value into ratio, width and validity.
// Assumes: purely combinational; the caller samples the result at run start.
module cfg_msel_decode
    import cfg_load_pkg::*;
(
    input  logic [4:0] msel_i,
    output msel_cfg_t  cfg_o
);

    // Decode validity, bus width and adjusted clock ratio
    always_comb begin
        cfg_o.bad   = msel_i[4] | (&msel_i[1:0]);
        cfg_o.wide  = msel_i[3];
        cfg_o.ratio = msel_i[1:0] + {1'b0, (msel_i[3] & (|msel_i[1:0]))};
    end

endmodule

// File: rtl/cfg_wait_timer.sv
// Wait timer: a cycle divider makes a tick; ticks count up to a limit.
// Assumes: restart_i clears both counters; expired_o stays high until restart.
module cfg_wait_timer #(
    parameter int TICK_DIV   = 125000,
    parameter int TICK_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);

    localparam int DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TICK_W = $clog2(TICK_LIMIT + 1);

    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;

    // Count system cycles into ticks and ticks up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (div_q == DIV_W'(TICK_DIV - 1)) begin
            div_q <= '0;
            if (tick_q != TICK_W'(TICK_LIMIT))
                tick_q <= tick_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign expired_o = (tick_q == TICK_W'(TICK_LIMIT));

    // R11: once expired, the timer stays expired until restarted
    a_r11_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !restart_i) |=> expired_o);

    // R11: the tick count never passes the limit
    a_r11_tick_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= TICK_W'(TICK_LIMIT));

endmodule

// File: rtl/cfg_load_seq.sv
// Configuration load sequencer: runs the reset, configure, clock burst and
// user-mode handshake with a fabric, forwarding image words on the way.
// Assumes: the fabric mode and monitor bits are synchronous to clk; image
// words arrive on a valid/ready stream whose last word is flagged.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DCLK_CNT_W  = 16,
    parameter int DCLK_PULSES = 4,
    parameter int TICK_DIV    = 125000,
    parameter int TICK_LIMIT  = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [4:0]            msel_i,
    input  logic [2:0]            fab_mode_i,
    input  logic                  conf_done_i,
    input  logic                  nstatus_i,
    input  logic                  dclk_done_i,
    input  logic                  img_valid_i,
    input  logic [DATA_W-1:0]     img_data_i,
    input  logic                  img_last_i,
    output logic                  img_ready_o,
    output logic                  ctl_en_o,
    output logic                  ctl_nce_o,
    output logic                  ctl_ncfg_pull_o,
    output logic                  ctl_stream_en_o,
    output logic [1:0]            ctl_ratio_o,
    output logic                  ctl_wide_o,
    output logic [DCLK_CNT_W-1:0] dclk_cnt_o,
    output logic                  dclk_req_o,
    output logic                  dclk_clr_o,
    output logic                  nst_clr_o,
    output logic                  wr_valid_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [1:0]            result_o
);

    seq_state_e state_q, state_d;
    msel_cfg_t  mcfg;
    logic       tmr_restart, tmr_expired, in_wait;
    logic       ev_bad, ev_setup, ev_rel, ev_stream, ev_word;
    logic       ev_conf, ev_dclk_go, ev_dclk_seen, ev_user, ev_tmo;

    cfg_msel_decode u_decode (
        .msel_i (msel_i),
        .cfg_o  (mcfg)
    );

    cfg_wait_timer #(
        .TICK_DIV   (TICK_DIV),
        .TICK_LIMIT (TICK_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .expired_o (tmr_expired)
    );

    // Next-state and one-cycle event decode for the load sequence
    always_comb begin
        state_d      = state_q;
        ev_bad       = 1'b0;
        ev_setup     = 1'b0;
        ev_rel       = 1'b0;
        ev_stream    = 1'b0;
        ev_word      = 1'b0;
        ev_conf      = 1'b0;
        ev_dclk_go   = 1'b0;
        ev_dclk_seen = 1'b0;
        ev_user      = 1'b0;
        ev_tmo       = 1'b0;
        in_wait      = (state_q == SQ_WAIT_RST)  || (state_q == SQ_WAIT_CFG)  ||
                       (state_q == SQ_WAIT_CONF) || (state_q == SQ_WAIT_DCLK) ||
                       (state_q == SQ_WAIT_USER);
        case (state_q)
            SQ_IDLE: if (start_i) begin
                if (mcfg.bad) begin
                    ev_bad = 1'b1;
                end else begin
                    ev_setup = 1'b1;
                    state_d  = SQ_WAIT_RST;
                end
            end
            SQ_WAIT_RST: if (fab_mode_i == FAB_RESET) begin
                ev_rel  = 1'b1;
                state_d = SQ_WAIT_CFG;
            end
            SQ_WAIT_CFG: if (fab_mode_i == FAB_CONFIG) begin
                ev_stream = 1'b1;
                state_d   = SQ_STREAM;
            end
            SQ_STREAM: if (img_valid_i) begin
                ev_word = 1'b1;
                if (img_last_i)
                    state_d = SQ_WAIT_CONF;
            end
            SQ_WAIT_CONF: if (conf_done_i || nstatus_i) begin
                ev_conf = 1'b1;
                state_d = SQ_DCLK_GO;
            end
            SQ_DCLK_GO: begin
                ev_dclk_go = 1'b1;
                state_d    = SQ_WAIT_DCLK;
            end
            SQ_WAIT_DCLK: if (dclk_done_i) begin
                ev_dclk_seen = 1'b1;
                state_d      = SQ_WAIT_USER;
            end
            SQ_WAIT_USER: if (fab_mode_i == FAB_USER) begin
                ev_user = 1'b1;
                state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
        if (in_wait && (state_d == state_q) && tmr_expired) begin
            ev_tmo  = 1'b1;
            state_d = SQ_IDLE;
        end
        tmr_restart = (state_d != state_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Control, strobe, write-port and result registers updated by events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en_o        <= 1'b0;
            ctl_nce_o       <= 1'b1;
            ctl_ncfg_pull_o <= 1'b0;
            ctl_stream_en_o <= 1'b0;
            ctl_ratio_o     <= 2'd0;
            ctl_wide_o      <= 1'b0;
            dclk_req_o      <= 1'b0;
            dclk_clr_o      <= 1'b0;
            nst_clr_o       <= 1'b0;
            wr_valid_o      <= 1'b0;
            wr_data_o       <= '0;
            done_o          <= 1'b0;
            result_o        <= RES_NONE;
        end else begin
            nst_clr_o  <= ev_stream;
            dclk_clr_o <= ev_conf | ev_dclk_seen;
            dclk_req_o <= ev_dclk_go;
            wr_valid_o <= ev_word;
            done_o     <= ev_bad | ev_user | ev_tmo;
            if (ev_word)
                wr_data_o <= img_data_i;
            if (ev_setup) begin
                ctl_ratio_o     <= mcfg.ratio;
                ctl_wide_o      <= mcfg.wide;
                ctl_nce_o       <= 1'b0;
                ctl_en_o        <= 1'b1;
                ctl_ncfg_pull_o <= 1'b1;
                result_o        <= RES_NONE;
            end
            if (ev_rel)    ctl_ncfg_pull_o <= 1'b0;
            if (ev_stream) ctl_stream_en_o <= 1'b1;
            if (ev_conf)   ctl_stream_en_o <= 1'b0;
            if (ev_user) begin
                ctl_en_o <= 1'b0;
                result_o <= RES_PASS;
            end
            if (ev_bad) result_o <= RES_FAIL;
            if (ev_tmo) result_o <= RES_TIMEOUT;
        end
    end

    assign img_ready_o = (state_q == SQ_STREAM);
    assign busy_o      = (state_q != SQ_IDLE);
    assign dclk_cnt_o  = DCLK_CNT_W'(DCLK_PULSES);

    // R12: strobes never overlap
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nst_clr_o, dclk_clr_o, dclk_req_o, done_o}));

    // R6: the stream is only accepted with the data path enabled
    a_r6_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> ctl_stream_en_o);

    // R7: written words only appear with the data path enabled
    a_r7_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> ctl_stream_en_o);

    // R5: reset release only follows a reset-phase report
    a_r5_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_ncfg_pull_o) |-> ($past(fab_mode_i) == 3'd1));

    // R2: a rejected strap leaves control untouched and reports fail
    a_r2_bad_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && start_i && mcfg.bad) |=>
        (result_o == 2'd2 && $stable(ctl_en_o) && $stable(ctl_nce_o) && $stable(ctl_ncfg_pull_o)));

    // R9: the burst request directly follows a done-flag clear
    a_r9_req_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_req_o |-> $past(dclk_clr_o));

    // R10: a pass hands the pins back
    a_r10_pass_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'd1) |-> !ctl_en_o);

endmodule

// File: tb/cfg_load_seq_test.sv
// Bench: a reactive fabric model plus an image driver; checks each run's
// strobes, words, control levels and result against bench functions.
module cfg_load_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  msel = 5'd0;
    logic [2:0]  fab_mode = 3'd0;
    logic        conf_done = 1'b0, nstatus = 1'b0, dclk_done = 1'b0;
    logic        img_valid = 1'b0, img_last = 1'b0;
    logic [31:0] img_data = 32'd0;

    logic        img_ready_o, ctl_en_o, ctl_nce_o, ctl_ncfg_pull_o, ctl_stream_en_o;
    logic [1:0]  ctl_ratio_o, result_o;
    logic        ctl_wide_o, dclk_req_o, dclk_clr_o, nst_clr_o, wr_valid_o, busy_o, done_o;
    logic [15:0] dclk_cnt_o;
    logic [31:0] wr_data_o;

    int n_cmp = 0, n_bad = 0;
    int hang_stage = 0, n_words = 1, mdl_stage = 0, mdl_dly = 0;
    bit use_nst = 0, run_over = 0;
    int wr_cnt = 0, nst_cnt = 0, clr_cnt = 0, req_cnt = 0, done_cnt = 0;
    logic [31:0] words [16];

    always #4 clk = ~clk;

    cfg_load_seq #(.TICK_DIV(4), .TICK_LIMIT(6)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .msel_i(msel),
        .fab_mode_i(fab_mode), .conf_done_i(conf_done), .nstatus_i(nstatus),
        .dclk_done_i(dclk_done), .img_valid_i(img_valid), .img_data_i(img_data),
        .img_last_i(img_last), .img_ready_o(img_ready_o), .ctl_en_o(ctl_en_o),
        .ctl_nce_o(ctl_nce_o), .ctl_ncfg_pull_o(ctl_ncfg_pull_o),
        .ctl_stream_en_o(ctl_stream_en_o), .ctl_ratio_o(ctl_ratio_o),
        .ctl_wide_o(ctl_wide_o), .dclk_cnt_o(dclk_cnt_o), .dclk_req_o(dclk_req_o),
        .dclk_clr_o(dclk_clr_o), .nst_clr_o(nst_clr_o), .wr_valid_o(wr_valid_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic bad_f(input logic [4:0] m);
        return m[4] | (m[1:0] == 2'b11);
    endfunction

    function automatic logic [1:0] ratio_f(input logic [4:0] m);
        logic [1:0] r;
        r = m[1:0];
        if (m[3] && m[1:0] != 2'b00) r = r + 2'd1;
        return r;
    endfunction

    // Monitor and fabric model, one process so counters and reactions agree
    initial forever begin
        logic trig;
        @(negedge clk);
        if (rst_n) begin
            if (nst_clr_o) begin nst_cnt++; chk("R6 stream on at clear", ctl_stream_en_o, 1); end
            if (dclk_clr_o) begin clr_cnt++; dclk_done = 1'b0; end
            if (dclk_req_o) begin req_cnt++; chk("R9 dclk count", dclk_cnt_o, 4); end
            if (wr_valid_o) begin
                chk("R7 word", wr_data_o, words[wr_cnt % 16]);
                chk("R7 stream on at write", ctl_stream_en_o, 1);
                wr_cnt++;
            end
            if (img_ready_o && !ctl_stream_en_o) chk("R6 ready gated", 0, 1);
            if (done_o) done_cnt++;
            case (mdl_stage)
                0: trig = ctl_en_o && ctl_ncfg_pull_o;
                1: trig = !ctl_ncfg_pull_o;
                2: trig = (wr_cnt == n_words);
                3: trig = (req_cnt > 0);
                4: trig = (clr_cnt >= 2);
                default: trig = 1'b0;
            endcase
            if (trig && (mdl_stage + 1 != hang_stage)) begin
                if (mdl_dly > 0) mdl_dly--;
                else begin
                    case (mdl_stage)
                        0: fab_mode = 3'd1;
                        1: fab_mode = 3'd2;
                        2: begin fab_mode = 3'd3; if (use_nst) nstatus = 1'b1; else conf_done = 1'b1; end
                        3: dclk_done = 1'b1;
                        4: fab_mode = 3'd4;
                        default: ;
                    endcase
                    mdl_stage++;
                    mdl_dly = $urandom_range(0, 6);
                end
            end
        end
    end

    task automatic drive_image();
        int idx = 0;
        while (!run_over && idx < n_words) begin
            @(negedge clk);
            img_valid = ($urandom_range(0, 3) != 0);
            img_data  = words[idx];
            img_last  = (idx == n_words - 1);
            if (img_valid && img_ready_o) idx++;
        end
        @(negedge clk);
        img_valid = 1'b0;
        img_last  = 1'b0;
    endtask

    // One complete run; hang selects the model stage that never answers
    task automatic run(input logic [4:0] m, input int hang, input bit nst,
                       input int nw, input bit restart_mid);
        logic en0, nce0, ncfg0;
        int k;
        @(negedge clk);
        hang_stage = hang; use_nst = nst; n_words = nw;
        for (int i = 0; i < 16; i++) words[i] = $urandom;
        wr_cnt = 0; nst_cnt = 0; clr_cnt = 0; req_cnt = 0; done_cnt = 0;
        mdl_stage = 0; mdl_dly = $urandom_range(0, 6);
        fab_mode = 3'd0; conf_done = 1'b0; nstatus = 1'b0; dclk_done = 1'b0;
        run_over = 0;
        msel = m;
        en0 = ctl_en_o; nce0 = ctl_nce_o; ncfg0 = ctl_ncfg_pull_o;
        start_i = 1'b1;
        fork drive_image(); join_none
        k = 0;
        do begin
            @(negedge clk);
            k++;
            start_i = restart_mid && (k == 4);
            if (restart_mid && k == 4) msel = 5'h10;
        end while (!done_o && k < 3000);
        start_i = 1'b0;
        run_over = 1;
        repeat (4) @(negedge clk);
        chk("R12 single done", done_cnt, 1);
        if (bad_f(m)) begin
            chk("R2 fail code", result_o, 2);
            chk("R2 en kept", ctl_en_o, en0);
            chk("R2 nce kept", ctl_nce_o, nce0);
            chk("R2 ncfg kept", ctl_ncfg_pull_o, ncfg0);
        end else if (hang != 0) begin
            chk("R11 timeout code", result_o, 3);
            if (hang == 1) begin
                chk("R11 timeout cycle", k, 26);
                chk("R4 en", ctl_en_o, 1);
                chk("R4 nce", ctl_nce_o, 0);
                chk("R4 ncfg pulled", ctl_ncfg_pull_o, 1);
                chk("R3 ratio", ctl_ratio_o, ratio_f(m));
                chk("R3 wide", ctl_wide_o, m[3]);
            end
            if (hang == 2) chk("R5 ncfg released", ctl_ncfg_pull_o, 0);
            if (hang == 3) chk("R8 stream held on", ctl_stream_en_o, 1);
        end else begin
            chk("R10 pass code", result_o, 1);
            chk("R10 en released", ctl_en_o, 0);
            chk("R4 nce", ctl_nce_o, 0);
            chk("R5 ncfg", ctl_ncfg_pull_o, 0);
            chk("R3 ratio", ctl_ratio_o, ratio_f(m));
            chk("R3 wide", ctl_wide_o, m[3]);
            chk("R8 stream off", ctl_stream_en_o, 0);
            chk("R6 one irq clear", nst_cnt, 1);
            chk("R9 two clears", clr_cnt, 2);
            chk("R9 one request", req_cnt, 1);
            chk("R7 word count", wr_cnt, nw);
            chk("R6 ready low after", img_ready_o, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 en", ctl_en_o, 0);
        chk("R1 nce", ctl_nce_o, 1);
        chk("R1 ncfg", ctl_ncfg_pull_o, 0);
        chk("R1 stream", ctl_stream_en_o, 0);
        chk("R1 ready", img_ready_o, 0);
        chk("R1 result", result_o, 0);
        chk("R1 strobes", {done_o, nst_clr_o, dclk_clr_o, dclk_req_o, wr_valid_o}, 0);
        run(5'h10, 0, 0, 3, 0);
        run(5'h03, 0, 0, 3, 0);
        run(5'h09, 0, 0, 4, 0);
        run(5'h0A, 0, 0, 1, 0);
        run(5'h08, 0, 0, 6, 0);
        run(5'h02, 0, 1, 5, 0);
        run(5'h0B, 0, 0, 2, 0);
        for (int h = 1; h <= 5; h++) run(5'h01, h, 0, 3, 0);
        run(5'h01, 0, 0, 8, 1);
        for (int i = 0; i < 14; i++)
            run(5'($urandom_range(0, 31)), 0, ($urandom_range(0, 1) == 1), $urandom_range(1, 12), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule